// File: doc/BRIEF.md
# Pin Function Select Register Block

This block holds, for every pin of a group of 32-pin ports, the choice between GPIO ownership and one of four peripheral functions. Software reaches it over a simple one-cycle write/read bus. Each port has a bank of three 32-bit registers: an ownership register (one bit per pin, 1 = GPIO owns the pin) and two function-select bit planes, called plane A (function bit 0) and plane B (function bit 1).

None of the three registers can be overwritten as a whole. Each one has a set alias and a clear alias, and a write to either changes only the bits written as one. This lets a driver move a single pin to a new function, or between GPIO and peripheral, without a read-modify-write sequence that another agent could interrupt. The block drives a 2-bit function code and a GPIO-ownership flag for every pin from the stored registers. The pad multiplexers downstream consume these outputs directly.

Top module: `pfmux_top`

## Requirements
- R1: After reset every pin is GPIO-owned (`pin_gpio_own` all ones), every function code is 0 and `bus_rvalid` is 0.
- R2: Global pin p belongs to port p/32, whose bank starts at byte address 0x100*(p/32), and uses bit p%32 of that bank's registers. Its outputs are `pin_gpio_own[p]` and `pin_func[2p+1:2p]`.
- R3: Within a bank, address bits [5:4] select the register (0 ownership, 1 plane A, 2 plane B) and bits [3:2] select the access (0 plain, 1 set alias, 2 clear alias). Bits [7:6] and [1:0] must be zero.
- R4: A write to a set alias ORs the write data into the register. Bits written as zero keep their value. The new value appears on the pin outputs in the cycle after the write.
- R5: A write to a clear alias clears the register bits written as one. All other bits keep their value. The new value appears on the pin outputs in the cycle after the write.
- R6: A pin's function code is {plane B bit, plane A bit}: 0 = both clear, 1 = only plane A set, 2 = only plane B set, 3 = both set.
- R7: Clearing a pin's ownership bit hands the pin to its selected peripheral (`pin_gpio_own` = 0). Setting the bit returns the pin to GPIO. The ownership bit does not change the function code.
- R8: A read returns the addressed register on `bus_rdata`, with `bus_rvalid` high, in the cycle after `bus_rd`. The plain address and both aliases of a register return the same value.
- R9: A write to a plain address, a reserved offset, a misaligned address or a port number at or above NUM_PORTS changes no register. A read of a reserved offset, misaligned address or absent port returns 0.
- R10: A read and a write in the same cycle are both accepted. The read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data (bit mask for aliases) |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| pin_gpio_own | output | NUM_PORTS*32 | 1 = pin owned by GPIO |
| pin_func | output | 2*NUM_PORTS*32 | Function code per pin |

## Verification
A read and a write can be accepted in the same cycle, and they can target the same register. The read must then return the value the register held before the write, and the pin outputs must show the value after the write. The bench provokes this with directed read-and-write pairs aimed at the same alias. Random traffic also raises both strobes together often. In every case a reference model captures the expected read value before it applies the write, and then compares both the read data and the pin outputs.

// File: rtl/pfmux_pkg.sv
package pfmux_pkg;

    localparam int PORT_PINS = 32;
    localparam int BANK_SPAN = 256;

    // register select, address bits [5:4]
    typedef enum logic [1:0] {
        REG_OWN  = 2'd0,
        REG_PLA  = 2'd1,
        REG_PLB  = 2'd2,
        REG_NONE = 2'd3
    } reg_kind_e;

    // access select, address bits [3:2]
    typedef enum logic [1:0] {
        ACC_PLAIN = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [PORT_PINS-1:0] own;
        logic [PORT_PINS-1:0] pla;
        logic [PORT_PINS-1:0] plb;
    } bank_t;

    localparam bank_t BANK_RESET = '{own: '1, pla: '0, plb: '0};

    typedef struct packed {
        logic                 rvalid;
        logic [PORT_PINS-1:0] rdata;
    } rd_t;

    function automatic logic [PORT_PINS-1:0] apply_acc(
        input logic [PORT_PINS-1:0] cur,
        input acc_e                 acc,
        input logic [PORT_PINS-1:0] mask
    );
        case (acc)
            ACC_SET: apply_acc = cur | mask;
            ACC_CLR: apply_acc = cur & ~mask;
            default: apply_acc = cur;
        endcase
    endfunction

endpackage

// File: rtl/pfmux_decode.sv
module pfmux_decode
    import pfmux_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_PORTS-1:0] port_hit,
    output reg_kind_e            kind,
    output acc_e                 acc
);
    localparam int PORT_W = ADDR_W - 8;

    logic legal;

    always_comb begin
        kind  = REG_NONE;
        acc   = ACC_NONE;
        legal = 1'b0;
        if (addr[1:0] == 2'b00 && addr[7:6] == 2'b00) begin
            kind  = reg_kind_e'(addr[5:4]);
            acc   = acc_e'(addr[3:2]);
            legal = (kind != REG_NONE) && (acc != ACC_NONE);
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        assign port_hit[p] = legal && (addr[ADDR_W-1:8] == PORT_W'(p));
    end

endmodule

// File: rtl/pfmux_bank.sv
module pfmux_bank
    import pfmux_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  reg_kind_e            kind,
    input  acc_e                 acc,
    input  logic [PORT_PINS-1:0] wdata,
    output logic [PORT_PINS-1:0] rd_val,
    output logic [PORT_PINS-1:0] own,
    output logic [PORT_PINS-1:0] pla,
    output logic [PORT_PINS-1:0] plb
);
    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            case (kind)
                REG_OWN: st_d.own = apply_acc(st_q.own, acc, wdata);
                REG_PLA: st_d.pla = apply_acc(st_q.pla, acc, wdata);
                REG_PLB: st_d.plb = apply_acc(st_q.plb, acc, wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BANK_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        case (kind)
            REG_OWN: rd_val = st_q.own;
            REG_PLA: rd_val = st_q.pla;
            REG_PLB: rd_val = st_q.plb;
            default: rd_val = '0;
        endcase
    end

    assign own = st_q.own;
    assign pla = st_q.pla;
    assign plb = st_q.plb;

endmodule

// File: rtl/pfmux_top.sv
module pfmux_top
    import pfmux_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_PORTS = 4,
    localparam int NUM_PINS = NUM_PORTS * PORT_PINS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [PORT_PINS-1:0]  bus_wdata,
    output logic [PORT_PINS-1:0]  bus_rdata,
    output logic                  bus_rvalid,
    output logic [NUM_PINS-1:0]   pin_gpio_own,
    output logic [2*NUM_PINS-1:0] pin_func
);
    logic [NUM_PORTS-1:0] port_hit;
    reg_kind_e            kind;
    acc_e                 acc;
    logic [PORT_PINS-1:0] bank_rd [NUM_PORTS];
    logic [PORT_PINS-1:0] bank_pla [NUM_PORTS];
    logic [PORT_PINS-1:0] bank_plb [NUM_PORTS];

    pfmux_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
        .addr     (bus_addr),
        .port_hit (port_hit),
        .kind     (kind),
        .acc      (acc)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
        pfmux_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (bus_wr && port_hit[p]),
            .kind   (kind),
            .acc    (acc),
            .wdata  (bus_wdata),
            .rd_val (bank_rd[p]),
            .own    (pin_gpio_own[p*PORT_PINS +: PORT_PINS]),
            .pla    (bank_pla[p]),
            .plb    (bank_plb[p])
        );

        for (genvar b = 0; b < PORT_PINS; b++) begin : g_pin
            assign pin_func[2*(p*PORT_PINS+b) +: 2] = {bank_plb[p][b], bank_pla[p][b]};
        end
    end

    // read path: registered, one cycle after the strobe
    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.rvalid = bus_rd;
        rd_d.rdata  = '0;
        if (bus_rd) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (port_hit[p]) rd_d.rdata = rd_d.rdata | bank_rd[p];
            end
        end else begin
            rd_d.rdata = rd_q.rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata  = rd_q.rdata;
    assign bus_rvalid = rd_q.rvalid;

endmodule

// File: rtl/pfmux_chk.sv
module pfmux_chk #(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 128
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic                  bus_rvalid,
    input logic [NUM_PINS-1:0]   pin_gpio_own,
    input logic [2*NUM_PINS-1:0] pin_func
);
    logic port0;
    assign port0 = (bus_addr[ADDR_W-1:8] == '0);

    // R8
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R8
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R9
    idle_pins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(pin_gpio_own) && $stable(pin_func)));

    // R9
    plain_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[7:0] == 8'h00) |=> ($stable(pin_gpio_own) && $stable(pin_func)));

    // R4
    own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && port0 && bus_addr[7:0] == 8'h04)
        |=> (pin_gpio_own[31:0] == ($past(pin_gpio_own[31:0]) | $past(bus_wdata))));

    // R5
    own_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && port0 && bus_addr[7:0] == 8'h08)
        |=> (pin_gpio_own[31:0] == ($past(pin_gpio_own[31:0]) & ~$past(bus_wdata))));

    // R7
    own_write_keeps_func_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[7:4] == 4'h0) |=> $stable(pin_func));

endmodule

bind pfmux_top pfmux_chk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_pfmux_chk (.*);

// File: tb/test_pfmux_top.sv
`timescale 1ns/1ps
module test_pfmux_top;
    localparam int AW  = 12;
    localparam int NP  = 4;
    localparam int NPI = NP * 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            bus_rvalid;
    logic [NPI-1:0]  pin_gpio_own;
    logic [2*NPI-1:0] pin_func;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_own [NP];
    logic [31:0] m_pla [NP];
    logic [31:0] m_plb [NP];

    always #2 clk = ~clk;

    pfmux_top #(.ADDR_W(AW), .NUM_PORTS(NP)) i_pfmux_top (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
        .bus_rdata, .bus_rvalid, .pin_gpio_own, .pin_func
    );

    function automatic bit legal(input logic [AW-1:0] a);
        return a[1:0] == 2'b00 && a[7:6] == 2'b00 && a[5:4] != 2'd3
            && a[3:2] != 2'd3 && int'(a[AW-1:8]) < NP;
    endfunction

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int p;
        if (!legal(a)) return '0;
        p = int'(a[AW-1:8]);
        case (a[5:4])
            2'd0: return m_own[p];
            2'd1: return m_pla[p];
            default: return m_plb[p];
        endcase
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
        int p;
        logic [31:0] v;
        if (!legal(a) || a[3:2] == 2'd0) return;
        p = int'(a[AW-1:8]);
        v = model_read(a);
        v = (a[3:2] == 2'd1) ? (v | d) : (v & ~d);
        case (a[5:4])
            2'd0: m_own[p] = v;
            2'd1: m_pla[p] = v;
            default: m_plb[p] = v;
        endcase
    endtask

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_pins(input string tag);
        logic [NPI-1:0]   e_own;
        logic [2*NPI-1:0] e_func;
        for (int p = 0; p < NPI; p++) begin
            e_own[p]        = m_own[p/32][p%32];
            e_func[2*p +: 2] = {m_plb[p/32][p%32], m_pla[p/32][p%32]};
        end
        chk(tag, 256'(pin_gpio_own), 256'(e_own), "pin_gpio_own");
        chk(tag, 256'(pin_func), 256'(e_func), "pin_func");
    endtask

    // one bus cycle; called at a falling edge, returns at the next one
    task automatic step(input bit wr, input bit rd, input logic [AW-1:0] a,
                        input logic [31:0] d, input string tag);
        logic [31:0] exp_r;
        exp_r     = model_read(a);   // R10: read sees pre-write value
        bus_wr    = wr;
        bus_rd    = rd;
        bus_addr  = a;
        bus_wdata = d;
        if (wr) model_write(a, d);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        chk(tag, 256'(bus_rvalid), 256'(rd), "bus_rvalid");
        if (rd) chk(tag, 256'(bus_rdata), 256'(exp_r), "bus_rdata");
        chk_pins(tag);
    endtask

    function automatic logic [AW-1:0] adr(input int port, input int kind, input int acc);
        return AW'(port * 256 + kind * 16 + acc * 4);
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        for (int p = 0; p < NP; p++) begin
            m_own[p] = '1; m_pla[p] = '0; m_plb[p] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", 256'(bus_rvalid), 256'(0), "bus_rvalid");
        chk_pins("R1");

        // R2 / R6: pin 37 = port 1 bit 5, walk through all four codes
        step(1, 0, adr(1, 1, 1), 32'h20, "R6");           // code 1
        step(1, 0, adr(1, 2, 1), 32'h20, "R6");           // code 3
        step(1, 0, adr(1, 1, 2), 32'h20, "R6");           // code 2
        chk("R2", 256'(pin_func[75:74]), 256'(2), "pin37 func");
        // R7 hand pin 37 to peripheral, then back
        step(1, 0, adr(1, 0, 2), 32'h20, "R7");
        chk("R7", 256'(pin_gpio_own[37]), 256'(0), "pin37 own");
        chk("R7", 256'(pin_func[75:74]), 256'(2), "pin37 func kept");
        step(1, 0, adr(1, 0, 1), 32'h20, "R7");
        // R2 last pin: port 3 bit 31
        step(1, 0, adr(3, 2, 1), 32'h8000_0000, "R2");
        chk("R2", 256'(pin_func[255:254]), 256'(2), "pin127 func");
        // R4 / R5 neighbouring bits untouched
        step(1, 0, adr(0, 1, 1), 32'hF0F0_F0F0, "R4");
        step(1, 0, adr(0, 1, 2), 32'h0000_00F0, "R5");
        // R8 read through all three addresses
        step(0, 1, adr(0, 1, 0), '0, "R8");
        step(0, 1, adr(0, 1, 1), '0, "R8");
        step(0, 1, adr(0, 1, 2), '0, "R8");
        // R3 / R9 plain, reserved, misaligned, absent port
        step(1, 1, adr(0, 1, 0), 32'hFFFF_FFFF, "R9");
        step(1, 1, adr(0, 3, 1), 32'hFFFF_FFFF, "R9");
        step(1, 1, adr(0, 1, 3), 32'hFFFF_FFFF, "R3");
        step(1, 1, adr(0, 1, 1) | AW'(1), 32'hFFFF_FFFF, "R9");
        step(1, 1, adr(0, 1, 1) | AW'(8'h40), 32'hFFFF_FFFF, "R3");
        step(1, 1, adr(NP, 1, 1), 32'hFFFF_FFFF, "R9");
        // R10 read and write of the same alias together
        step(1, 1, adr(2, 2, 1), 32'h0000_FFFF, "R10");
        step(1, 1, adr(2, 2, 2), 32'h0000_00FF, "R10");
        step(0, 1, adr(2, 2, 0), '0, "R10");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int port, kind, acc;
            logic [AW-1:0] a;
            logic [31:0]   d;
            port = $urandom_range(0, NP);
            kind = $urandom_range(0, 3);
            acc  = $urandom_range(0, 3);
            a = adr(port, kind, acc);
            if ($urandom_range(0, 15) == 0) a[1:0] = 2'($urandom_range(1, 3));
            d = ($urandom_range(0, 1) == 1) ? $urandom() : (32'h1 << $urandom_range(0, 31));
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d, "R4/R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule